// File: doc/BRIEF.md
# Upgrade Control Serial Access Port

This block gives user logic a serial window onto the upgrade controller's control and status words. A 41-bit shift register moves data in and out one bit per clock. Its lower 39 bits are the data field. Its top two bits form a source selector that chooses which status word a capture loads. A separate 39-bit control register receives the data field on an update. Only two bits of that register are kept: an image select bit and an override enable bit. When override is on, the stored select bit decides the boot image; when it is off, the external select pin decides.

Two control inputs set what happens on each clock: shift-not-load and capture-not-update. With shift-not-load high, the register shifts and the capture control has no effect. With both low, the control register loads from the data field. With shift-not-load low and capture high, the data field loads one of four parallel words. The selector is fed from the same serial stream as the data field. After a shift it holds the last two bits shifted in. It is never changed by a capture or an update, so one selector write can be followed by any number of captures.

Top module: `upg_ser_port`

## Requirements
- R1: While rst_ni is low, the shift register and the control register are all zeros. Therefore ser_o is 0 and img_sel_o follows sel_pin_i.
- R2: With shift_nld_i high, each rising clock edge sets data field bits 38:0 to {ser_i, old bits 38:1}, whatever capt_nupd_i is. ser_o always shows data bit 0.
- R3: The selector bits 40:39 become {ser_i, old bit 40} on a shift edge. They are unchanged on capture and update edges.
- R4: With both controls low, the control register loads from data field bits 38:0, and the shift register is unchanged.
- R5: On a capture with selector 00, the data field loads the current-state word. That word has msm_state_i in bits 33:30, wdog_en_i in bit 29, and zeros elsewhere.
- R6: On a capture with selector 01 the data field loads prev1_i. With selector 10 it loads prev2_i. Both are zero-extended in bits 38:32.
- R7: On a capture with selector 11, the data field loads the control register contents.
- R8: Only control register bits 13 (image select) and 12 (override enable) can become 1. All other bits stay 0 whatever value is loaded.
- R9: img_sel_o equals control bit 13 when control bit 12 is 1. Otherwise it equals sel_pin_i.
- R10: The control register keeps its value on every edge that is not an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock; all registers are rising-edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data in |
| shift_nld_i | input | 1 | High: shift; low: load operation |
| capt_nupd_i | input | 1 | With shift_nld_i low: high captures, low updates |
| msm_state_i | input | 4 | Master state for the current-state word |
| wdog_en_i | input | 1 | Watchdog-enable flag for the current-state word |
| prev1_i | input | 32 | First previous-state word |
| prev2_i | input | 32 | Second previous-state word |
| sel_pin_i | input | 1 | External image select pin |
| ser_o | output | 1 | Serial data out (data bit 0) |
| img_sel_o | output | 1 | Effective boot image select |

## Verification
Shifts use irregular bit patterns while capt_nupd_i toggles. This shows whether the capture control is truly ignored, and whether the selector snoops the last two serial bits and no others. All four selector values are captured with distinct, asymmetric status words and then shifted out in full. This separates correct source routing and zero-extension from swapped or shifted fields. Repeated captures after a single selector write, with status words changed between them, confirm that the selector survives capture. Control loads cover an all-ones word and a select-without-override word, each with the pin toggled. Together they expose any reserved bit that leaks and any wrong pin/register priority.

// File: rtl/upg_pkg.sv
package upg_pkg;
  localparam int DATA_W  = 39;
  localparam int SEL_W   = 2;
  localparam int SR_W    = DATA_W + SEL_W;
  localparam int MSM_W   = 4;
  localparam int STAT_W  = 32;
  localparam int MSM_LSB = 30;
  localparam int WDE_BIT = 29;
  localparam int IMG_BIT = 13;
  localparam int OVR_BIT = 12;

  typedef enum logic [SEL_W-1:0] {
    SRC_CUR   = 2'b00,
    SRC_PREV1 = 2'b01,
    SRC_PREV2 = 2'b10,
    SRC_CTRL  = 2'b11
  } cap_src_e;

  typedef enum logic [1:0] {
    OP_UPDATE  = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } port_op_e;
endpackage

// File: rtl/upg_op_dec.sv
module upg_op_dec
  import upg_pkg::*;
(
  input  logic     shift_nld_i,
  input  logic     capt_nupd_i,
  output port_op_e op_o
);
  always_comb begin
    if (shift_nld_i)      op_o = OP_SHIFT;
    else if (capt_nupd_i) op_o = OP_CAPTURE;
    else                  op_o = OP_UPDATE;
  end
endmodule

// File: rtl/upg_cap_mux.sv
module upg_cap_mux
  import upg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int MW  = MSM_W,
  parameter int SW  = STAT_W,
  parameter int MLSB = MSM_LSB,
  parameter int WBIT = WDE_BIT
) (
  input  cap_src_e        src_i,
  input  logic [MW-1:0]   msm_i,
  input  logic            wde_i,
  input  logic [SW-1:0]   prev1_i,
  input  logic [SW-1:0]   prev2_i,
  input  logic [DW-1:0]   ctrl_i,
  output logic [DW-1:0]   word_o
);
  logic [DW-1:0] cur_w, p1_w, p2_w;

  always_comb begin
    cur_w = '0;
    cur_w[MLSB +: MW] = msm_i;
    cur_w[WBIT]       = wde_i;
  end

  // zero-extend or truncate previous-state words to the data field
  generate
    if (SW < DW) begin : g_ext
      assign p1_w = {{(DW-SW){1'b0}}, prev1_i};
      assign p2_w = {{(DW-SW){1'b0}}, prev2_i};
    end else begin : g_trunc
      assign p1_w = prev1_i[DW-1:0];
      assign p2_w = prev2_i[DW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_CUR:   word_o = cur_w;
      SRC_PREV1: word_o = p1_w;
      SRC_PREV2: word_o = p2_w;
      default:   word_o = ctrl_i;
    endcase
  end
endmodule

// File: rtl/upg_shift_reg.sv
module upg_shift_reg
  import upg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SL = SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_op_e          op_i,
  input  logic              ser_i,
  input  logic [DW-1:0]     cap_word_i,
  output logic [DW+SL-1:0]  sr_o
);
  localparam int TW = DW + SL;
  logic [TW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      unique case (op_i)
        OP_SHIFT: begin
          // selector snoops the serial stream; data field shifts toward bit 0
          sr_q[TW-1:DW]   <= {ser_i, sr_q[TW-1 -: SL-1]};
          sr_q[DW-1:0]    <= {ser_i, sr_q[DW-1:1]};
        end
        OP_CAPTURE: sr_q[DW-1:0] <= cap_word_i;
        default: ;
      endcase
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/upg_ctrl_reg.sv
module upg_ctrl_reg
  import upg_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int IBIT = IMG_BIT,
  parameter int OBIT = OVR_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  port_op_e      op_i,
  input  logic [DW-1:0] data_i,
  input  logic          sel_pin_i,
  output logic [DW-1:0] ctrl_o,
  output logic          img_sel_o
);
  localparam logic [DW-1:0] ONE       = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] KEEP_MASK = (ONE << IBIT) | (ONE << OBIT);

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= '0;
    else if (op_i == OP_UPDATE) ctrl_q <= data_i & KEEP_MASK;
  end

  assign ctrl_o    = ctrl_q;
  assign img_sel_o = ctrl_q[OBIT] ? ctrl_q[IBIT] : sel_pin_i;
endmodule

// File: rtl/upg_ser_port.sv
module upg_ser_port
  import upg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              shift_nld_i,
  input  logic              capt_nupd_i,
  input  logic [MSM_W-1:0]  msm_state_i,
  input  logic              wdog_en_i,
  input  logic [STAT_W-1:0] prev1_i,
  input  logic [STAT_W-1:0] prev2_i,
  input  logic              sel_pin_i,
  output logic              ser_o,
  output logic              img_sel_o
);
  port_op_e          op_w;
  logic [SR_W-1:0]   sr_w;
  logic [DATA_W-1:0] ctrl_w;
  logic [DATA_W-1:0] cap_w;
  cap_src_e          src_w;

  upg_op_dec u_dec (
    .shift_nld_i (shift_nld_i),
    .capt_nupd_i (capt_nupd_i),
    .op_o        (op_w)
  );

  assign src_w = cap_src_e'(sr_w[SR_W-1:DATA_W]);

  upg_cap_mux u_mux (
    .src_i   (src_w),
    .msm_i   (msm_state_i),
    .wde_i   (wdog_en_i),
    .prev1_i (prev1_i),
    .prev2_i (prev2_i),
    .ctrl_i  (ctrl_w),
    .word_o  (cap_w)
  );

  upg_shift_reg u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_w),
    .ser_i      (ser_i),
    .cap_word_i (cap_w),
    .sr_o       (sr_w)
  );

  upg_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op_w),
    .data_i    (sr_w[DATA_W-1:0]),
    .sel_pin_i (sel_pin_i),
    .ctrl_o    (ctrl_w),
    .img_sel_o (img_sel_o)
  );

  assign ser_o = sr_w[0];
endmodule

// File: rtl/upg_ser_port_chk.sv
module upg_ser_port_chk
  import upg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_i,
  input logic              shift_nld_i,
  input logic              capt_nupd_i,
  input logic [MSM_W-1:0]  msm_state_i,
  input logic              wdog_en_i,
  input logic [SR_W-1:0]   sr_q,
  input logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] KEEP = (ONE << IMG_BIT) | (ONE << OVR_BIT);

  logic is_upd, is_cap;
  assign is_upd = !shift_nld_i && !capt_nupd_i;
  assign is_cap = !shift_nld_i && capt_nupd_i;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_nld_i |=> (sr_q[DATA_W-1] == $past(ser_i)) &&
                    (sr_q[DATA_W-2:0] == $past(sr_q[DATA_W-1:1])));

  // R3
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_nld_i |=> $stable(sr_q[SR_W-1:DATA_W]));

  // R4
  upd_sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_upd |=> $stable(sr_q));

  // R5
  cap_cur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cap && sr_q[SR_W-1:DATA_W] == 2'b00) |=>
      (sr_q[DATA_W-1:0] == ((DATA_W'($past(msm_state_i)) << MSM_LSB) |
                            (DATA_W'($past(wdog_en_i)) << WDE_BIT))));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~KEEP) == '0);

  // R10
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_upd |=> $stable(ctrl_q));
endmodule

bind upg_ser_port upg_ser_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_i       (ser_i),
  .shift_nld_i (shift_nld_i),
  .capt_nupd_i (capt_nupd_i),
  .msm_state_i (msm_state_i),
  .wdog_en_i   (wdog_en_i),
  .sr_q        (sr_w),
  .ctrl_q      (ctrl_w)
);

// File: tb/upg_ser_port_tb.sv
module upg_ser_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ser_i = 1'b0;
  logic        shift_nld_i = 1'b0;
  logic        capt_nupd_i = 1'b0;
  logic [3:0]  msm_state_i = 4'h0;
  logic        wdog_en_i = 1'b0;
  logic [31:0] prev1_i = '0;
  logic [31:0] prev2_i = '0;
  logic        sel_pin_i = 1'b0;
  logic        ser_o, img_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [40:0] m_sr   = '0;
  logic [38:0] m_ctrl = '0;

  always #5 clk_i = ~clk_i;

  upg_ser_port u_dut (
    .clk_i, .rst_ni, .ser_i, .shift_nld_i, .capt_nupd_i,
    .msm_state_i, .wdog_en_i, .prev1_i, .prev2_i, .sel_pin_i,
    .ser_o, .img_sel_o
  );

  function automatic logic [38:0] cap_word(logic [1:0] s);
    logic [38:0] w = '0;
    case (s)
      2'b00: begin w[33:30] = msm_state_i; w[29] = wdog_en_i; end
      2'b01: w = {7'b0, prev1_i};
      2'b10: w = {7'b0, prev2_i};
      default: w = m_ctrl;
    endcase
    return w;
  endfunction

  task automatic compare(input string tag);
    logic exp_img;
    exp_img = m_ctrl[12] ? m_ctrl[13] : sel_pin_i;
    checks++;
    if (ser_o !== m_sr[0]) begin
      fails++;
      $display("FAIL %s ser_o actual=%b expected=%b", tag, ser_o, m_sr[0]);
    end
    checks++;
    if (img_sel_o !== exp_img) begin
      fails++;
      $display("FAIL %s img_sel_o actual=%b expected=%b", tag, img_sel_o, exp_img);
    end
  endtask

  task automatic step(input logic s, input logic sh, input logic cp, input string tag);
    ser_i = s; shift_nld_i = sh; capt_nupd_i = cp;
    @(posedge clk_i);
    if (sh) begin
      m_sr = {s, m_sr[40], s, m_sr[38:1]};
    end else if (cp) begin
      m_sr[38:0] = cap_word(m_sr[40:39]);
    end else begin
      m_ctrl = '0;
      m_ctrl[13] = m_sr[13];
      m_ctrl[12] = m_sr[12];
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_ni = 1'b0;
    m_sr = '0; m_ctrl = '0;
    @(negedge clk_i);
    compare(tag);
    sel_pin_i = ~sel_pin_i;
    #1 compare(tag);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic shift_word(input logic [38:0] w, input string tag);
    for (int i = 0; i < 39; i++) step(w[i], 1'b1, i[0], tag);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 39; i++) begin
      if (i % 7 == 3) sel_pin_i = ~sel_pin_i;
      step(i[1], 1'b1, ~i[0], tag);
    end
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    do_reset("R1");

    // R2/R3: irregular shift pattern, capture control toggling
    for (int i = 0; i < 45; i++) step(((i * 5 + 3) % 7) > 2, 1'b1, i[1], "R2");
    step(1'b0, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, "R3");

    msm_state_i = 4'hA; wdog_en_i = 1'b1;
    prev1_i = 32'hC35A_0F81; prev2_i = 32'h8000_7E13;

    // R5: selector 00 via bits 38:37 of the shifted word
    shift_word(39'h00_1234_5678, "R5");
    step(1'b0, 1'b0, 1'b1, "R5");
    drain("R5");

    // R6: selector 01 then 10
    shift_word({2'b01, 37'h0_DEAD_BEEF}, "R6");
    step(1'b0, 1'b0, 1'b1, "R6");
    drain("R6");
    shift_word({2'b10, 37'h1_5555_AAAA}, "R6");
    step(1'b0, 1'b0, 1'b1, "R6");
    drain("R6");

    // R3: repeated capture with one selector write, status changed
    shift_word({2'b01, 37'h0}, "R3");
    step(1'b0, 1'b0, 1'b1, "R3");
    prev1_i = 32'h0F0F_1234;
    step(1'b0, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b0, "R4");
    prev1_i = 32'h7654_3210;
    step(1'b0, 1'b0, 1'b1, "R3");
    drain("R3");

    // R4/R8/R9: load all ones, override on with image 1
    shift_word('1, "R4");
    step(1'b0, 1'b0, 1'b0, "R4");
    sel_pin_i = 1'b0;
    #1 compare("R9");
    step(1'b0, 1'b0, 1'b1, "R7");
    drain("R8");

    // R10: shifts and captures leave control unchanged
    for (int i = 0; i < 10; i++) begin
      sel_pin_i = i[0];
      step(i[2], i[1], 1'b1, "R10");
    end

    // R9: image select set, override off -> pin decides
    shift_word({2'b11, 23'h0, 1'b1, 1'b0, 12'hFFF}, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");
    sel_pin_i = 1'b1; #1 compare("R9");
    sel_pin_i = 1'b0; #1 compare("R9");
    step(1'b0, 1'b0, 1'b1, "R7");
    drain("R7");

    // R8: override only, image bit clear, reserved bits set
    shift_word({2'b11, 25'h1FF_FFFF, 1'b0, 1'b1, 12'hABC}, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    sel_pin_i = 1'b1; #1 compare("R9");
    step(1'b0, 1'b0, 1'b1, "R8");
    drain("R8");

    // R1: reset mid-run clears both registers
    do_reset("R1");
    step(1'b0, 1'b0, 1'b1, "R1");
    drain("R1");

    done = 1;
    report();
    $finish;
  end
endmodule